// File: doc/BRIEF.md
# Sprite Pixel Coordinate Sequencer

This block walks through the pixels of a small fixed ball shape and presents one screen coordinate per clock. A caller gives an anchor made of the leftmost column and the topmost row of the shape, then pulses a start strobe. From the very next cycle the block produces the five coordinates of a plus-shaped ball, one on each consecutive cycle. It raises a done flag in the same cycle as the fifth coordinate, so the caller can chain a new action with no idle or trailing cycle.

Coordinates are 9 bits for x and 8 bits for y, which is enough to address a 320 by 240 bitmap. The anchor is captured when start is taken, so the caller may change the anchor inputs while a draw is running. The coordinate outputs keep their last value between draws. They carry no valid flag of their own, so downstream write logic must gate them with its own enable.

The controller has two states. IDLE waits for start. DRAW emits the shape. The transition IDLE->DRAW (named LAUNCH) fires when start is sampled high in IDLE. DRAW->DRAW (named STEP) fires while the current pixel is not the fifth. DRAW->IDLE (named FINISH) fires on the edge that ends the done cycle.

Top module: `sprite_coord_seq`

## Requirements
- R1: When start is sampled high on a clock edge while the block is idle, the cycle after that edge shows x_out = x_in+1 and y_out = y_in, using the x_in and y_in values present at that edge.
- R2: The following four cycles show, in order, these offsets (dx,dy) from the anchor: (0,1), (1,1), (2,1), (1,2). Each new coordinate appears on the cycle right after the previous one.
- R3: Anchor plus offset is computed modulo 512 for x and modulo 256 for y.
- R4: Each draw emits exactly five coordinates. After the fifth, the block returns to idle.
- R5: done is high only in the cycle that shows the fifth coordinate, and it stays high for exactly one cycle.
- R6: start is ignored while a draw is in progress, including the done cycle. Holding start high does not lengthen or restart the draw in progress.
- R7: Changes to x_in and y_in after the edge that launched a draw have no effect on that draw.
- R8: While idle, x_out and y_out hold the last emitted coordinate and done stays low.
- R9: A synchronous reset returns the block to idle with x_out = 0, y_out = 0 and done = 0. It takes effect even in the middle of a draw.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe, sampled in IDLE only |
| x_in | input | 9 | Leftmost column of the shape |
| y_in | input | 8 | Topmost row of the shape |
| x_out | output | 9 | Column of the current pixel |
| y_out | output | 8 | Row of the current pixel |
| done | output | 1 | High with the fifth pixel |

## Verification
The hardest case to reach from the ports is a start that arrives while the controller sits in its last DRAW cycle, since that is the one edge where a careless design could relaunch or extend the draw. The stimulus reaches it by holding start high through entire draws, so the done edge and the idle cycle after it both see start asserted. In the same draws the anchor inputs are inverted right after launch, to show that the launching values alone shape the output. Every x anchor and every y anchor is swept, including the wrapping corners at 511 and 255, and one draw is cut short by reset.

// File: rtl/sprite_seq_pkg.sv
package sprite_seq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DRAW = 1'b1
    } seq_state_t;

    // Number of pixels in the fixed plus-shaped ball
    localparam int unsigned PIX_COUNT = 5;
    localparam int unsigned IDX_W     = $clog2(PIX_COUNT);
    // Offsets within the shape span 0..2
    localparam int unsigned OFF_W     = 2;

endpackage

// File: rtl/sprite_shape_lut.sv
module sprite_shape_lut
    import sprite_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] dx,
    output logic [OFF_W-1:0] dy
);

    // Plus sign: top, left, centre, right, bottom
    always_comb begin
        dx = '0;
        dy = '0;
        unique case (idx)
            IDX_W'(0): begin dx = OFF_W'(1); dy = OFF_W'(0); end
            IDX_W'(1): begin dx = OFF_W'(0); dy = OFF_W'(1); end
            IDX_W'(2): begin dx = OFF_W'(1); dy = OFF_W'(1); end
            IDX_W'(3): begin dx = OFF_W'(2); dy = OFF_W'(1); end
            IDX_W'(4): begin dx = OFF_W'(1); dy = OFF_W'(2); end
            default:   begin dx = '0;        dy = '0;        end
        endcase
    end

endmodule

// File: rtl/sprite_seq_ctrl.sv
module sprite_seq_ctrl
    import sprite_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load,
    output logic             emit,
    output logic [IDX_W-1:0] idx_next,
    output logic             busy,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_COUNT - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             at_last;
    logic             advance;

    always_comb begin
        at_last  = (idx_q == LAST_IDX);
        load     = (state_q == ST_IDLE) && start;
        advance  = (state_q == ST_DRAW) && !at_last;
        emit     = load || advance;
        idx_next = load ? '0 : idx_q + IDX_W'(1);
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_DRAW;   // LAUNCH
            ST_DRAW: if (at_last) state_d = ST_IDLE;   // FINISH, else STEP
            default:              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (emit) idx_q <= idx_next;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= emit && (idx_next == LAST_IDX);
    end

    assign busy = (state_q == ST_DRAW);

endmodule

// File: rtl/sprite_coord_gen.sv
module sprite_coord_gen
    import sprite_seq_pkg::*;
#(
    parameter int unsigned XW = 9,
    parameter int unsigned YW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             emit,
    input  logic [XW-1:0]    x_in,
    input  logic [YW-1:0]    y_in,
    input  logic [OFF_W-1:0] dx,
    input  logic [OFF_W-1:0] dy,
    output logic [XW-1:0]    x_out,
    output logic [YW-1:0]    y_out
);

    logic [XW-1:0] anchor_x;
    logic [YW-1:0] anchor_y;
    logic [XW-1:0] base_x, sum_x;
    logic [YW-1:0] base_y, sum_y;

    always_comb begin
        base_x = load ? x_in : anchor_x;
        base_y = load ? y_in : anchor_y;
        sum_x  = base_x + {{(XW-OFF_W){1'b0}}, dx};
        sum_y  = base_y + {{(YW-OFF_W){1'b0}}, dy};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            anchor_x <= '0;
            anchor_y <= '0;
        end else if (load) begin
            anchor_x <= x_in;
            anchor_y <= y_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_out <= '0;
            y_out <= '0;
        end else if (emit) begin
            x_out <= sum_x;
            y_out <= sum_y;
        end
    end

endmodule

// File: rtl/sprite_coord_seq.sv
module sprite_coord_seq
    import sprite_seq_pkg::*;
#(
    parameter int unsigned XW = 9,
    parameter int unsigned YW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [XW-1:0] x_in,
    input  logic [YW-1:0] y_in,
    output logic [XW-1:0] x_out,
    output logic [YW-1:0] y_out,
    output logic          done
);

    logic             load;
    logic             emit;
    logic             busy;
    logic [IDX_W-1:0] idx_next;
    logic [OFF_W-1:0] dx, dy;

    sprite_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load     (load),
        .emit     (emit),
        .idx_next (idx_next),
        .busy     (busy),
        .done     (done)
    );

    sprite_shape_lut u_lut (
        .idx (idx_next),
        .dx  (dx),
        .dy  (dy)
    );

    sprite_coord_gen #(.XW(XW), .YW(YW)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .emit  (emit),
        .x_in  (x_in),
        .y_in  (y_in),
        .dx    (dx),
        .dy    (dy),
        .x_out (x_out),
        .y_out (y_out)
    );

endmodule

// File: rtl/sprite_coord_chk.sv
module sprite_coord_chk #(
    parameter int unsigned XW = 9,
    parameter int unsigned YW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [XW-1:0] x_in,
    input logic [YW-1:0] y_in,
    input logic [XW-1:0] x_out,
    input logic [YW-1:0] y_out,
    input logic          done,
    input logic          busy
);

    logic [3:0] pix_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 pix_cnt <= '0;
        else if (!busy && start) pix_cnt <= 4'd1;
        else if (busy && !done)  pix_cnt <= pix_cnt + 4'd1;
    end

    AST_FIRST_PIXEL: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (x_out == XW'($past(x_in) + XW'(1))) && (y_out == $past(y_in))); // R1
    AST_PIXEL_COUNT: assert property (@(posedge clk) disable iff (rst)
        done |-> (pix_cnt == 4'd5)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_DONE_IN_DRAW: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R5
    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R6
    AST_END_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(x_out) && $stable(y_out) && !done)); // R8

endmodule

bind sprite_coord_seq sprite_coord_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .x_in  (x_in),
    .y_in  (y_in),
    .x_out (x_out),
    .y_out (y_out),
    .done  (done),
    .busy  (busy)
);

// File: tb/tb_sprite_coord_seq.sv
module tb_sprite_coord_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [8:0] x_in;
    logic [7:0] y_in;
    logic [8:0] x_out;
    logic [7:0] y_out;
    logic       done;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sprite_coord_seq dut (
        .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
        .x_out(x_out), .y_out(y_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int off_x(input int i);
        case (i)
            0: return 1;
            1: return 0;
            2: return 1;
            3: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int off_y(input int i);
        case (i)
            0: return 0;
            4: return 2;
            default: return 1;
        endcase
    endfunction

    // Called at a negedge with the block idle
    task automatic draw(input logic [8:0] ax, input logic [7:0] ay,
                        input bit hold, input bit scramble, input string tag);
        logic [8:0] ex;
        logic [7:0] ey;
        ex = '0;
        ey = '0;
        start = 1'b1;
        x_in  = ax;
        y_in  = ay;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i == 0) begin
                if (!hold) start = 1'b0;
                if (scramble) begin x_in = ~ax; y_in = ~ay; end
            end
            ex = ax + 9'(off_x(i));
            ey = ay + 8'(off_y(i));
            chk(x_out == ex, (i == 0) ? "R1" : (scramble ? "R7" : tag), "x_out", x_out, ex);
            chk(y_out == ey, (i == 0) ? "R1" : (scramble ? "R7" : tag), "y_out", y_out, ey);
            chk(done == (i == 4), "R5", "done", done, (i == 4));
        end
        @(negedge clk);
        chk(done == 1'b0, hold ? "R6" : "R4", "done after draw", done, 0);
        chk(x_out == ex && y_out == ey, hold ? "R6" : "R4", "coord after draw",
            {x_out, y_out}, {ex, ey});
        start = 1'b0;
        if (hold) begin
            @(negedge clk);
            chk(done == 1'b0 && x_out == ex && y_out == ey, "R8", "idle hold",
                {done, x_out, y_out}, {1'b0, ex, ey});
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; x_in = '0; y_in = '0;
        repeat (3) @(negedge clk);
        chk(x_out == 0 && y_out == 0 && done == 0, "R9", "reset state",
            {done, x_out, y_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        x_in = 9'd77; y_in = 8'd33;
        @(negedge clk);
        chk(x_out == 0 && y_out == 0 && done == 0, "R8", "idle without start",
            {done, x_out, y_out}, 0);

        draw(9'd100, 8'd50, 0, 0, "R2");

        // Sweep every x anchor
        for (int x = 0; x < 512; x++)
            draw(9'(x), 8'((x * 37 + 11) & 255), (x % 7) == 0, (x % 5) == 0, "R2");
        // Sweep every y anchor
        for (int y = 0; y < 256; y++)
            draw(9'((y * 113 + 5) & 511), 8'(y), (y % 3) == 0, (y % 4) == 0, "R2");

        // Wrapping corners
        draw(9'd511, 8'd255, 0, 0, "R3");
        draw(9'd510, 8'd254, 1, 0, "R3");
        draw(9'd511, 8'd0,   0, 1, "R3");
        draw(9'd0,   8'd255, 1, 1, "R3");

        // Reset during a draw
        start = 1'b1; x_in = 9'd200; y_in = 8'd100;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(x_out == 0 && y_out == 0 && done == 0, "R9", "reset mid-draw",
            {done, x_out, y_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(x_out == 0 && y_out == 0 && done == 0, "R9", "idle after reset",
            {done, x_out, y_out}, 0);
        draw(9'd300, 8'd200, 0, 0, "R2");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule